// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block sits between a PC-style host bus and a floppy controller core. It decodes a chip select, separate read and write strobes and three address bits. Two registers are kept locally: a write-only drive control register and a write-only data rate register. Reads of the status and data locations, and writes to the data location, pass straight through to the core. One read location returns the drive's disk-changed flag on the top data bit only.

The drive control register selects a drive, switches the four motors and enables DMA. It also holds the core's active-low reset bit. The core therefore stays in reset after a hardware reset until software sets that bit. Clearing and then setting the bit again restarts the core and leaves both host registers as they are. When DMA is disabled, the request and interrupt outputs float and the acknowledge input is blocked. Every tri-state output is modelled as a value plus an output enable.

Writes take effect on the clock edge that samples the strobe. The read path is combinational.

Top module: `fdc_host_regs`

## Requirements
- R1: A write to address 3'b010 loads the 8-bit drive control register on the next clock edge. Its layout is [1:0] drive number, [2] core run bit (active-low reset), [3] DMA enable, and [7:4] motor enables for drives 3..0, where bit 4+n belongs to drive n.
- R2: A write to address 3'b111 loads din[1:0] into the rate output on the next edge. The encoding is 00 = 500 kb/s, 01 = 300 kb/s, 10 = 250 kb/s and 11 = 1 Mb/s.
- R3: A read of address 3'b100 (status) or 3'b101 (data) drives core_rdata on all eight bits with dout_oe = 8'hFF and pulses core_rd. A write to 3'b101 pulses core_wr with core_wdata = din. In both cases core_a0 carries addr[0].
- R4: A read of address 3'b111 drives only bit 7, with dout_oe = 8'h80 and dout[7] = disk_changed.
- R5: Every other combination leaves dout_oe = 0, core_rd = core_wr = 0 and both registers unchanged. This covers unlisted addresses, a read of 3'b010, a write to 3'b100, no chip select, and both strobes high at once.
- R6: While rst is high, the drive control register is cleared to 8'h00 and the rate is set to 2'b10 (250 kb/s).
- R7: core_reset is high whenever rst is high or the run bit (bit 2) of the drive control register is 0.
- R8: Writing the drive control register with bit 2 cleared and then with bit 2 set raises core_reset and then releases it. The rate register keeps its value throughout, and the drive control register holds exactly what was written.
- R9: With DMA enable at 0, drq_oe and irq_oe are 0 and core_dack_n is 1. With DMA enable at 1, both output enables are 1, drq and irq follow core_drq and core_irq, and core_dack_n follows dack_n.
- R10: drive_sel[n] is 1 only when the drive number field equals n and motor enable bit 4+n is set.
- R11: motor_on[n] equals drive control bit 4+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, active high |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 3 | Register address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 8 | Per-bit output enable for dout |
| core_rd | output | 1 | Read strobe to core |
| core_wr | output | 1 | Write strobe to core |
| core_a0 | output | 1 | Core register select (0 status, 1 data) |
| core_wdata | output | 8 | Write data to core |
| core_rdata | input | 8 | Read data from core |
| disk_changed | input | 1 | Disk-changed flag from the drive |
| core_reset | output | 1 | Reset to core, active high |
| core_drq | input | 1 | DMA request from core |
| core_irq | input | 1 | Interrupt from core |
| drq | output | 1 | DMA request to host |
| drq_oe | output | 1 | Output enable for drq |
| irq | output | 1 | Interrupt to host |
| irq_oe | output | 1 | Output enable for irq |
| dack_n | input | 1 | DMA acknowledge from host, active low |
| core_dack_n | output | 1 | Gated acknowledge to core |
| drive_sel | output | 4 | Drive select lines |
| motor_on | output | 4 | Motor enable lines |
| rate | output | 2 | Data rate code |

## Verification
The hardest case to reach is the software reset sequence (R8) with a non-default rate already loaded. In that case a faulty design that reloads the rate while the core is in reset shows a difference. The bench first writes a rate other than 250 kb/s. It then writes the drive control register with the run bit cleared and afterwards set, while DMA and motors are enabled. A second hardware reset is applied in the middle of random traffic so that R6 is seen after registers hold arbitrary values. The random phase also drives the collision and unused-address cases of R5 on every cycle.

// File: rtl/fdc_host_regs.sv
module fdc_host_regs #(
  parameter int DW = 8,
  parameter int NDRV = 4,
  parameter logic [1:0] RATE_RST = 2'b10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] dout_oe,
  output logic          core_rd,
  output logic          core_wr,
  output logic          core_a0,
  output logic [DW-1:0] core_wdata,
  input  logic [DW-1:0] core_rdata,
  input  logic          disk_changed,
  output logic          core_reset,
  input  logic          core_drq,
  input  logic          core_irq,
  output logic          drq,
  output logic          drq_oe,
  output logic          irq,
  output logic          irq_oe,
  input  logic          dack_n,
  output logic          core_dack_n,
  output logic [NDRV-1:0] drive_sel,
  output logic [NDRV-1:0] motor_on,
  output logic [1:0]    rate
);
  localparam logic [2:0] A_CTRL = 3'b010;
  localparam logic [2:0] A_STAT = 3'b100;
  localparam logic [2:0] A_DATA = 3'b101;
  localparam logic [2:0] A_RATE = 3'b111;
  localparam int SELW = $clog2(NDRV);

  logic [DW-1:0] ctrl_q;
  logic [1:0]    rate_q;
  logic          rd_go, wr_go;
  logic          dma_en, run;
  logic [SELW-1:0] unit;

  assign rd_go = cs && rd && !wr;
  assign wr_go = cs && wr && !rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rate_q <= RATE_RST;
    end else if (wr_go) begin
      if (addr == A_CTRL) ctrl_q <= din;
      if (addr == A_RATE) rate_q <= din[1:0];
    end
  end

  assign unit   = ctrl_q[SELW-1:0];
  assign run    = ctrl_q[2];
  assign dma_en = ctrl_q[3];
  assign rate   = rate_q;

  assign core_reset = rst || !run;

  assign core_rd    = rd_go && (addr == A_STAT || addr == A_DATA);
  assign core_wr    = wr_go && (addr == A_DATA);
  assign core_a0    = addr[0];
  assign core_wdata = din;

  always_comb begin
    dout    = '0;
    dout_oe = '0;
    if (core_rd) begin
      dout    = core_rdata;
      dout_oe = '1;
    end else if (rd_go && addr == A_RATE) begin
      dout[DW-1]    = disk_changed;
      dout_oe[DW-1] = 1'b1;
    end
  end

  assign drq_oe      = dma_en;
  assign irq_oe      = dma_en;
  assign drq         = core_drq;
  assign irq         = core_irq;
  assign core_dack_n = dack_n || !dma_en;

  for (genvar n = 0; n < NDRV; n++) begin : g_drv
    assign motor_on[n]  = ctrl_q[4+n];
    assign drive_sel[n] = (unit == SELW'(n)) && ctrl_q[4+n];
  end

  p_hw_reset_r6: assert property (@(posedge clk)
    $fell(rst) |-> (motor_on == '0 && rate == RATE_RST && core_reset));

  p_run_bit_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_go && addr == A_CTRL && !din[2]) |=> core_reset);

  p_swreset_keeps_rate_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_go && addr == A_CTRL) |=> $stable(rate));

  p_dma_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !drq_oe |-> (core_dack_n && !irq_oe));

  p_one_drive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drive_sel));

  p_bus_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd && !wr) |-> (dout_oe == '0 && !core_rd));

  p_d7_only_r4: assert property (@(posedge clk) disable iff (rst)
    (dout_oe != '0 && !core_rd) |-> (dout_oe == 8'h80));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(core_rd && core_wr));
endmodule

// File: tb/fdc_host_regs_test.sv
module fdc_host_regs_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst = 1, cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] din = 0, core_rdata = 0;
  logic disk_changed = 0, core_drq = 0, core_irq = 0, dack_n = 1;
  logic [7:0] dout, dout_oe, core_wdata;
  logic core_rd, core_wr, core_a0, core_reset, drq, drq_oe, irq, irq_oe, core_dack_n;
  logic [3:0] drive_sel, motor_on;
  logic [1:0] rate;

  int compared = 0, mismatched = 0;
  int m_ctrl = 0, m_rate = 2;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  fdc_host_regs uut (.clk, .rst, .cs, .rd, .wr, .addr, .din, .dout, .dout_oe,
    .core_rd, .core_wr, .core_a0, .core_wdata, .core_rdata, .disk_changed,
    .core_reset, .core_drq, .core_irq, .drq, .drq_oe, .irq, .irq_oe, .dack_n,
    .core_dack_n, .drive_sel, .motor_on, .rate);

  // reference model state
  always @(posedge clk) begin
    if (rst) begin m_ctrl = 0; m_rate = 2; end
    else if (cs && wr && !rd) begin
      if (addr == 2) m_ctrl = din;
      if (addr == 7) m_rate = din[1:0];
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit r, w, dma;
    int e_d, e_oe, sel;
    r = cs && rd && !wr; w = cs && wr && !rd;
    dma = m_ctrl[3]; sel = m_ctrl & 3;
    e_d = 0; e_oe = 0;
    if (r && (addr == 4 || addr == 5)) begin e_d = core_rdata; e_oe = 8'hFF; end
    else if (r && addr == 7) begin e_d = disk_changed ? 8'h80 : 0; e_oe = 8'h80; end
    chk("R3/R4/R5 dout", dout, e_d);
    chk("R3/R4/R5 dout_oe", dout_oe, e_oe);
    chk("R3 core_rd", core_rd, r && (addr == 4 || addr == 5));
    chk("R3 core_wr", core_wr, w && addr == 5);
    chk("R3 core_a0", core_a0, addr[0]);
    chk("R3 core_wdata", core_wdata, din);
    chk("R1 R11 motor_on", motor_on, (m_ctrl >> 4) & 15);
    chk("R10 drive_sel", drive_sel, ((m_ctrl >> (4 + sel)) & 1) << sel);
    chk("R2 R6 R8 rate", rate, m_rate);
    chk("R7 core_reset", core_reset, rst || !m_ctrl[2]);
    chk("R9 drq_oe", drq_oe, dma);
    chk("R9 irq_oe", irq_oe, dma);
    chk("R9 drq", drq, core_drq);
    chk("R9 irq", irq, core_irq);
    chk("R9 core_dack_n", core_dack_n, dack_n || !dma);
  end

  task automatic bus(bit r, bit w, logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cs = r | w; rd = r; wr = w; addr = a; din = d;
    @(posedge clk); #1;
    cs = 0; rd = 0; wr = 0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    $display("FAIL watchdog expired");
    mismatched++; compared++;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R6 reset state observed by compare; R7 core held in reset
    repeat (2) @(posedge clk);
    bus(0, 1, 3'b111, 8'h03);            // R2 rate 1 Mb/s
    bus(0, 1, 3'b010, 8'b0011_1001);      // R1 motors 0,1 on, DMA on, run=0, drive 1
    core_drq = 1; core_irq = 1; dack_n = 0;
    @(posedge clk);
    bus(0, 1, 3'b010, 8'b0011_1101);      // R8 release core
    bus(0, 1, 3'b010, 8'b0011_1001);      // R8 assert core reset
    bus(0, 1, 3'b010, 8'b0011_1101);      // R8 release again, rate must stay 11
    core_rdata = 8'hA5; bus(1, 0, 3'b100, 0);  // R3 status
    core_rdata = 8'h3C; bus(1, 0, 3'b101, 0);  // R3 data
    bus(0, 1, 3'b101, 8'h77);                  // R3 core write
    disk_changed = 1; bus(1, 0, 3'b111, 0);    // R4
    bus(1, 0, 3'b010, 0);                      // R5 read of write-only
    bus(0, 1, 3'b100, 8'hFF);                  // R5 write of read-only
    bus(0, 1, 3'b000, 8'hFF);                  // R5 unused
    bus(0, 1, 3'b010, 8'b1000_0011);           // R10 drive 3, DMA off (R9)
    bus(0, 1, 3'b010, 8'b0100_0011);           // R10 drive 3 motor off
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      cs = $urandom_range(0, 3) != 0;
      rd = $urandom_range(0, 1); wr = $urandom_range(0, 1);
      addr = $urandom_range(0, 7); din = $urandom;
      core_rdata = $urandom; disk_changed = $urandom_range(0, 1);
      core_drq = $urandom_range(0, 1); core_irq = $urandom_range(0, 1);
      dack_n = $urandom_range(0, 1);
      rst = (i >= 1500 && i < 1503);       // R6 mid-run hardware reset
    end
    @(posedge clk); #1; cs = 0; rd = 0; wr = 0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule